// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between six interrupt request flags and a processor's instruction sequencer. The six flags are external 0, timer 0, external 1, timer 1, serial (receive or transmit, merged into one flag) and timer 2. Each source can be enabled on its own, and one global gate lets all six through or blocks them all. Each source is assigned to one of two priority levels. At every instruction boundary the controller picks one winner. A high-level request beats a low-level one. Within a level, a fixed poll order breaks ties.

An accepted interrupt produces a one-cycle request to the processor, together with the 8-bit vector address of the handler. In the same cycle, acknowledge pulses go to the sources whose flags hardware clears. The serial flag gets no acknowledge, so its handler software clears it itself.

Two in-service bits, one per level, record which levels are being handled. A low-level handler can be pre-empted by a high-level request. A high-level handler cannot be pre-empted. A return strobe releases the highest active level. Saving the return address and the sequencing itself are done by the processor.

Top module: `vic_top`

## Requirements
- R1: While reset is active and after it is released, `cpu_req_o`, `vector_o`, `ack_o` and `inserv_o` are all zero, and the enable and priority registers hold zero.
- R2: When bit 6 of the enable register (the global gate, written through `en_data_i[6]`) is 0, no request is accepted, whatever the per-source bits are.
- R3: A source whose enable bit (`en_data_i[i]`, for source index i) is 0 is never accepted. Other enabled sources are still served.
- R4: The source indices are 0=external 0, 1=timer 0, 2=external 1, 3=timer 1, 4=serial and 5=timer 2. When source i is accepted, `vector_o` is 0x03 + 8*i, giving 0x03, 0x0B, 0x13, 0x1B, 0x23 and 0x2B. In all other cycles `vector_o` is 0.
- R5: Among requests at the same level, the lowest source index wins.
- R6: A priority bit of 1 (`prio_data_i[i]`) places source i at the high level. A high-level request wins over any simultaneous low-level request.
- R7: A request is accepted only on a clock edge where `insn_end_i` is 1. `cpu_req_o` rises in the cycle after that edge and lasts exactly one cycle.
- R8: While only the low in-service bit is set, further low-level requests are held off, and a high-level request is still accepted.
- R9: While the high in-service bit is set, no request of either level is accepted.
- R10: Acceptance sets `inserv_o[1]` (high) or `inserv_o[0]` (low). A pulse on `reti_i` clears the highest set bit only.
- R11: `ack_o` is one-hot, with the bit of the accepted source, during the `cpu_req_o` cycle. It stays zero when the serial source (index 4) is accepted, and zero in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 6 | Request flags, indexed by source |
| insn_end_i | input | 1 | Instruction boundary strobe; acceptance is allowed only when it is 1 |
| reti_i | input | 1 | Return-from-handler strobe |
| en_wr_i | input | 1 | Write strobe for the enable register |
| en_data_i | input | 7 | Enable value: bit 6 is the global gate, bits 5:0 are the per-source enables |
| prio_wr_i | input | 1 | Write strobe for the priority register |
| prio_data_i | input | 6 | Priority value: 1 selects the high level for that source |
| cpu_req_o | output | 1 | One-cycle interrupt request to the processor |
| vector_o | output | 8 | Handler address, valid while `cpu_req_o` is 1 |
| ack_o | output | 6 | Acknowledge pulses that clear the source flags |
| inserv_o | output | 2 | In-service bits: [1] high level, [0] low level |

## Verification
On every cycle, the in-line properties check the following:
- the request is a single-cycle pulse;
- nothing is accepted behind a closed global gate or a busy high level;
- no second low-level acceptance happens while a low handler runs;
- the acknowledge is one-hot and travels with the request;
- a return clears exactly the top in-service bit.

Other behaviour can only be shown by the directed scenarios, because it depends on which inputs were presented:
- the exact vector for each source;
- the poll order among simultaneous requests;
- the high-over-low choice;
- the serial source getting no acknowledge;
- the nested pre-emption sequence.

// File: rtl/vic_pkg.sv
package vic_pkg;
    // Defaults shared by the controller modules
    localparam int NSRC_DEF     = 6;
    localparam int VEC_W_DEF    = 8;
    localparam int VEC_BASE_DEF = 3;
    localparam int VEC_STEP_DEF = 8;
    localparam int NLVL         = 2;

    // Service level of an accepted request
    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;
endpackage

// File: rtl/vic_cfg_regs.sv
module vic_cfg_regs #(
    parameter int NSRC = vic_pkg::NSRC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_wr_i,
    input  logic [NSRC:0]   en_data_i,
    input  logic            prio_wr_i,
    input  logic [NSRC-1:0] prio_data_i,
    output logic            glob_en_o,
    output logic [NSRC-1:0] src_en_o,
    output logic [NSRC-1:0] hi_sel_o
);
    typedef struct packed {
        logic            glob;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] hi;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (en_wr_i) begin
            cfg_d.glob = en_data_i[NSRC];
            cfg_d.en   = en_data_i[NSRC-1:0];
        end
        if (prio_wr_i) begin
            cfg_d.hi = prio_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign glob_en_o = cfg_q.glob;
    assign src_en_o  = cfg_q.en;
    assign hi_sel_o  = cfg_q.hi;

    // R3: a write to the enable register shows up one cycle later
    a_r3_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (src_en_o == $past(en_data_i[NSRC-1:0])));
endmodule

// File: rtl/vic_poll_pick.sv
module vic_poll_pick #(
    parameter int NSRC  = vic_pkg::NSRC_DEF,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  cand_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [NSRC-1:0]  onehot_o
);
    // Scan from the top index down so the lowest index is the last one written and wins
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            onehot_o[i] = any_o && (idx_o == IDX_W'(i));
        end
    end
endmodule

// File: rtl/vic_level_track.sv
module vic_level_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_lo_i,
    input  logic       set_hi_i,
    input  logic       reti_i,
    output logic [1:0] inserv_o
);
    typedef struct packed {
        logic [1:0] inserv;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [1:0] after_ret;

    always_comb begin
        after_ret = trk_q.inserv;
        if (reti_i) begin
            if (trk_q.inserv[1]) begin
                after_ret[1] = 1'b0;
            end else begin
                after_ret[0] = 1'b0;
            end
        end
        trk_d.inserv = after_ret | {set_hi_i, set_lo_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign inserv_o = trk_q.inserv;

    // R10: a return with both levels active leaves only the low level
    a_r10_ret_top_only: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && inserv_o == 2'b11 && !set_lo_i && !set_hi_i) |=> (inserv_o == 2'b01));

    // R10: a return with only the low level active clears it
    a_r10_ret_low: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && inserv_o == 2'b01 && !set_lo_i && !set_hi_i) |=> (inserv_o == 2'b00));

    // R10: acceptance sets the matching level bit
    a_r10_set_hi: assert property (@(posedge clk) disable iff (!rst_n)
        set_hi_i |=> inserv_o[1]);
endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int              NSRC     = vic_pkg::NSRC_DEF,
    parameter int              VEC_W    = vic_pkg::VEC_W_DEF,
    parameter int              VEC_BASE = vic_pkg::VEC_BASE_DEF,
    parameter int              VEC_STEP = vic_pkg::VEC_STEP_DEF,
    parameter logic [NSRC-1:0] ACK_MASK = 6'b101111
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  irq_req_i,
    input  logic             insn_end_i,
    input  logic             reti_i,
    input  logic             en_wr_i,
    input  logic [NSRC:0]    en_data_i,
    input  logic             prio_wr_i,
    input  logic [NSRC-1:0]  prio_data_i,
    output logic             cpu_req_o,
    output logic [VEC_W-1:0] vector_o,
    output logic [NSRC-1:0]  ack_o,
    output logic [1:0]       inserv_o
);
    import vic_pkg::*;

    localparam int IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic             req;
        lvl_e             lvl;
        logic [VEC_W-1:0] vec;
        logic [NSRC-1:0]  ack;
    } out_t;

    out_t out_d, out_q;

    logic            glob_en;
    logic [NSRC-1:0] src_en;
    logic [NSRC-1:0] hi_sel;
    logic [1:0]      inserv;

    logic [NLVL-1:0][NSRC-1:0]  cand;
    logic [NLVL-1:0]            any_l;
    logic [NLVL-1:0][IDX_W-1:0] idx_l;
    logic [NLVL-1:0][NSRC-1:0]  oh_l;

    logic             take_hi;
    logic             take_lo;
    logic [IDX_W-1:0] sel_idx;
    logic [NSRC-1:0]  sel_oh;

    vic_cfg_regs #(.NSRC(NSRC)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_wr_i     (en_wr_i),
        .en_data_i   (en_data_i),
        .prio_wr_i   (prio_wr_i),
        .prio_data_i (prio_data_i),
        .glob_en_o   (glob_en),
        .src_en_o    (src_en),
        .hi_sel_o    (hi_sel)
    );

    // Split the gated requests into one candidate vector per level
    always_comb begin
        cand[LVL_LO] = irq_req_i & src_en & ~hi_sel & {NSRC{glob_en}};
        cand[LVL_HI] = irq_req_i & src_en &  hi_sel & {NSRC{glob_en}};
    end

    genvar g;
    for (g = 0; g < NLVL; g++) begin : g_lvl
        vic_poll_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
            .cand_i   (cand[g]),
            .any_o    (any_l[g]),
            .idx_o    (idx_l[g]),
            .onehot_o (oh_l[g])
        );
    end

    vic_level_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_lo_i (take_lo),
        .set_hi_i (take_hi),
        .reti_i   (reti_i),
        .inserv_o (inserv)
    );

    // Acceptance decision and the registered request
    always_comb begin
        take_hi = insn_end_i && any_l[LVL_HI] && !inserv[1];
        take_lo = insn_end_i && any_l[LVL_LO] && (inserv == 2'b00) && !take_hi;
        sel_idx = take_hi ? idx_l[LVL_HI] : idx_l[LVL_LO];
        sel_oh  = take_hi ? oh_l[LVL_HI]  : oh_l[LVL_LO];

        out_d     = '0;
        out_d.req = take_hi || take_lo;
        out_d.lvl = take_hi ? LVL_HI : LVL_LO;
        if (out_d.req) begin
            out_d.vec = VEC_W'(VEC_BASE) + VEC_W'(sel_idx) * VEC_W'(VEC_STEP);
            out_d.ack = sel_oh & ACK_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cpu_req_o = out_q.req;
    assign vector_o  = out_q.vec;
    assign ack_o     = out_q.ack;
    assign inserv_o  = inserv;

    // R7: the request to the processor lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req_o |=> !cpu_req_o);

    // R7: no acceptance without an instruction boundary
    a_r7_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_end_i |=> !cpu_req_o);

    // R2: a closed global gate blocks every source
    a_r2_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_en |=> !cpu_req_o);

    // R9: a running high-level handler is never pre-empted
    a_r9_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        inserv[1] |=> !cpu_req_o);

    // R8: a running low-level handler holds off other low requests
    a_r8_lo_blocks_lo: assert property (@(posedge clk) disable iff (!rst_n)
        inserv[0] |=> !(cpu_req_o && out_q.lvl == LVL_LO));

    // R11: the acknowledge is one-hot and only travels with a request
    a_r11_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o) && ((ack_o == '0) || cpu_req_o));

    // R4: the vector is zero outside a request cycle
    a_r4_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req_o |-> (vector_o == '0));
endmodule

// File: tb/vic_top_tb.sv
module vic_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] irq_req;
    logic       insn_end;
    logic       reti;
    logic       en_wr;
    logic [6:0] en_data;
    logic       prio_wr;
    logic [5:0] prio_data;
    logic       cpu_req;
    logic [7:0] vector;
    logic [5:0] ack;
    logic [1:0] inserv;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vic_top u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req_i   (irq_req),
        .insn_end_i  (insn_end),
        .reti_i      (reti),
        .en_wr_i     (en_wr),
        .en_data_i   (en_data),
        .prio_wr_i   (prio_wr),
        .prio_data_i (prio_data),
        .cpu_req_o   (cpu_req),
        .vector_o    (vector),
        .ack_o       (ack),
        .inserv_o    (inserv)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [6:0] en, input logic [5:0] pr);
        en_wr = 1'b1; en_data = en; prio_wr = 1'b1; prio_data = pr;
        @(negedge clk);
        en_wr = 1'b0; prio_wr = 1'b0;
    endtask

    // One boundary, then checks on the following cycle and on the one after it
    task automatic boundary(input logic hit, input logic [7:0] vec, input logic [5:0] ak,
                            input logic [1:0] is, input string tag);
        insn_end = 1'b1;
        @(negedge clk);
        insn_end = 1'b0;
        chk({tag, " req"}, 32'(cpu_req), 32'(hit));
        chk({tag, " vec"}, 32'(vector), hit ? 32'(vec) : 32'h0);
        chk({tag, " ack"}, 32'(ack), hit ? 32'(ak) : 32'h0);
        chk({tag, " inserv"}, 32'(inserv), 32'(is));
        irq_req = '0;
        @(negedge clk);
        chk({tag, " pulse end R7"}, 32'(cpu_req), 32'h0);
    endtask

    task automatic ret(input logic [1:0] is, input string tag);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
        chk({tag, " R10 after return"}, 32'(inserv), 32'(is));
    endtask

    task automatic t_reset;
        chk("R1 req", 32'(cpu_req), 0);
        chk("R1 vec", 32'(vector), 0);
        chk("R1 ack", 32'(ack), 0);
        chk("R1 inserv", 32'(inserv), 0);
        irq_req = 6'h3F;
        boundary(1'b0, 8'h00, 6'h00, 2'b00, "R1 cleared enables");
    endtask

    task automatic t_global;
        cfg(7'h3F, 6'h00);
        irq_req = 6'h3F;
        boundary(1'b0, 8'h00, 6'h00, 2'b00, "R2 gate closed");
    endtask

    task automatic t_mask;
        cfg(7'h48, 6'h00);
        irq_req = 6'h3F;
        boundary(1'b1, 8'h1B, 6'h08, 2'b01, "R3 only timer 1 enabled");
        ret(2'b00, "R3");
        irq_req = 6'h37;
        boundary(1'b0, 8'h00, 6'h00, 2'b00, "R3 masked sources");
    endtask

    task automatic t_vectors;
        cfg(7'h7F, 6'h00);
        for (int i = 0; i < 6; i++) begin
            logic [5:0] ek;
            ek = (i == 4) ? 6'h00 : 6'(1 << i);
            irq_req = 6'(1 << i);
            boundary(1'b1, 8'(3 + 8 * i), ek, 2'b01, $sformatf("R4 R11 source %0d", i));
            ret(2'b00, "R4");
        end
    endtask

    task automatic t_order;
        cfg(7'h7F, 6'h00);
        irq_req = 6'h3F;
        boundary(1'b1, 8'h03, 6'h01, 2'b01, "R5 all low");
        ret(2'b00, "R5");
        irq_req = 6'h36;
        boundary(1'b1, 8'h0B, 6'h02, 2'b01, "R5 lowest of 1,2,4,5");
        ret(2'b00, "R5");
        irq_req = 6'h30;
        boundary(1'b1, 8'h23, 6'h00, 2'b01, "R5 serial before timer 2");
        ret(2'b00, "R5");
    endtask

    task automatic t_prio;
        cfg(7'h7F, 6'h20);
        irq_req = 6'h3F;
        boundary(1'b1, 8'h2B, 6'h20, 2'b10, "R6 high beats low");
        ret(2'b00, "R6");
    endtask

    task automatic t_boundary;
        cfg(7'h7F, 6'h00);
        irq_req = 6'h04;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R7 no boundary", 32'(cpu_req), 0);
        end
        boundary(1'b1, 8'h13, 6'h04, 2'b01, "R7 at boundary");
        ret(2'b00, "R7");
    endtask

    task automatic t_nest;
        cfg(7'h7F, 6'h22);
        irq_req = 6'h01;
        boundary(1'b1, 8'h03, 6'h01, 2'b01, "R8 low accepted");
        irq_req = 6'h04;
        boundary(1'b0, 8'h00, 6'h00, 2'b01, "R8 low held off");
        irq_req = 6'h20;
        boundary(1'b1, 8'h2B, 6'h20, 2'b11, "R8 high pre-empts");
        irq_req = 6'h02;
        boundary(1'b0, 8'h00, 6'h00, 2'b11, "R9 high not pre-empted");
        irq_req = 6'h04;
        boundary(1'b0, 8'h00, 6'h00, 2'b11, "R9 low blocked");
        ret(2'b01, "R10 top level");
        ret(2'b00, "R10 low level");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; insn_end = 1'b0; reti = 1'b0;
        en_wr = 1'b0; en_data = '0; prio_wr = 1'b0; prio_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 in reset req", 32'(cpu_req), 0);
        chk("R1 in reset inserv", 32'(inserv), 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_global();
        t_mask();
        t_vectors();
        t_order();
        t_prio();
        t_boundary();
        t_nest();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule